// File: doc/BRIEF.md
# Endpoint Descriptor Locator

This block finds the transfer descriptor that a DMA engine should use for an endpoint that has just won arbitration. The arbiter hands it a physical endpoint number with a one-cycle request. The block then reads the endpoint's pointer from a table in memory. The table starts at a base address held in a register, and each endpoint has one 32-bit slot in it.

The block reads the descriptor's status word to see whether the descriptor has been retired. If it has, and the control word says a successor exists, the block follows the link. It writes the new pointer back into the endpoint's slot and tests the successor in the same way. It finishes with a one-cycle completion pulse. The pulse carries either the address of a usable descriptor or a request for software to supply a new one.

The block remembers the endpoint it last served and that endpoint's descriptor. When the same endpoint asks again and its descriptor has not been retired, the block answers at once, with no memory traffic. All memory traffic goes through one word-wide port that is held until the memory raises ready.

Top module: `dd_locator`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `mem_rd` and `mem_wr` are all low.
- R2: A fetch first reads the endpoint's table slot at byte address `tbl_base + 4*req_ep`.
- R3: If the pointer read from the slot is zero, the block pulses `done` with `irq` high and `desc_addr` zero, and makes no further access.
- R4: For a nonzero pointer P, the block reads the status word at P+12. If bit 0 of that word (retired) is clear, it pulses `done` with `irq` low and `desc_addr` = P.
- R5: If the retired bit is set, the block reads the control word at P+4. If bit 2 of that word (next valid) is set, it reads the link word at P and takes that word as the new pointer.
- R6: A followed link is written back to the endpoint's table slot. If the link is zero, the block then raises `irq` as in R3. Otherwise it repeats the status check of R4 on the new descriptor, and this may continue across several links.
- R7: A request for the endpoint whose descriptor was last found, with no retirement since, gives `done` on the next cycle with that same `desc_addr`, and makes no memory access.
- R8: The remembered descriptor is forgotten when a different endpoint is requested, when an `irq` outcome ends a fetch, or on a `desc_retired` pulse. A `desc_retired` pulse in the same cycle as a request forces a full fetch.
- R9: A retired descriptor whose next-valid bit is clear ends the fetch with `irq` high after exactly three accesses: slot, status and control.
- R10: `mem_rd` and `mem_wr` are never both high. While an access waits for `mem_ready`, its strobe, address and write data are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | AW | Byte address of the per-endpoint pointer table |
| req_valid | input | 1 | One-cycle request, taken while `busy` is low |
| req_ep | input | EPW | Physical endpoint number of the request |
| desc_retired | input | 1 | Pulse: the current descriptor has been retired |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | With `done`: a new descriptor is needed |
| desc_addr | output | AW | With `done` and `irq` low: the usable descriptor address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | AW | Memory write data |
| mem_rdata | input | AW | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access complete |

## Verification
Two functions can fall in the same cycle: a retirement pulse and a new request for the very endpoint whose descriptor is remembered. One clears the remembered descriptor, and the other would reuse it. The bench drives `desc_retired` and `req_valid` together on a single edge, just after a successful fetch for that endpoint. It judges the outcome by the number of memory accesses the request causes, which must be a full two-access fetch and not the zero-access shortcut. The returned address must still be correct. Varied memory latencies also make the completion of a fetch land next to the next request.

// File: rtl/dd_locator.sv
module dd_locator #(
  parameter int AW      = 32,
  parameter int EPW     = 5,
  parameter int RET_BIT = 0,
  parameter int NXT_BIT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  tbl_base,
  input  logic           req_valid,
  input  logic [EPW-1:0] req_ep,
  input  logic           desc_retired,
  output logic           busy,
  output logic           done,
  output logic           irq,
  output logic [AW-1:0]  desc_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [AW-1:0]  mem_wdata,
  input  logic [AW-1:0]  mem_rdata,
  input  logic           mem_ready
);
  typedef enum logic [2:0] {S_IDLE, S_PTR, S_STAT, S_CTRL, S_NEXT, S_WB} st_t;

  st_t            st;
  logic [EPW-1:0] ep, last_ep;
  logic [AW-1:0]  ptr;
  logic           proceed;

  wire [AW-1:0] slot = tbl_base + AW'({ep, 2'b00});
  wire          hit  = proceed && (req_ep == last_ep) && !desc_retired;

  assign busy      = (st != S_IDLE);
  assign mem_rd    = (st == S_PTR) || (st == S_STAT) || (st == S_CTRL) || (st == S_NEXT);
  assign mem_wr    = (st == S_WB);
  assign mem_wdata = ptr;

  always_comb begin
    case (st)
      S_STAT:  mem_addr = ptr + AW'(12);
      S_CTRL:  mem_addr = ptr + AW'(4);
      S_NEXT:  mem_addr = ptr;
      default: mem_addr = slot;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      irq       <= 1'b0;
      desc_addr <= '0;
      ep        <= '0;
      last_ep   <= '0;
      ptr       <= '0;
      proceed   <= 1'b0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      if (desc_retired) proceed <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (hit) begin
            done      <= 1'b1;
            desc_addr <= ptr;
          end else begin
            proceed <= 1'b0;
            ep      <= req_ep;
            st      <= S_PTR;
          end
        end
        S_PTR: if (mem_ready) begin
          ptr <= mem_rdata;
          if (mem_rdata == '0) begin
            done <= 1'b1; irq <= 1'b1; desc_addr <= '0; st <= S_IDLE;
          end else st <= S_STAT;
        end
        S_STAT: if (mem_ready) begin
          if (!mem_rdata[RET_BIT]) begin
            done <= 1'b1; desc_addr <= ptr; proceed <= 1'b1; last_ep <= ep; st <= S_IDLE;
          end else st <= S_CTRL;
        end
        S_CTRL: if (mem_ready) begin
          if (mem_rdata[NXT_BIT]) st <= S_NEXT;
          else begin
            done <= 1'b1; irq <= 1'b1; desc_addr <= '0; st <= S_IDLE;
          end
        end
        S_NEXT: if (mem_ready) begin
          ptr <= mem_rdata;
          st  <= S_WB;
        end
        S_WB: if (mem_ready) begin
          if (ptr == '0) begin
            done <= 1'b1; irq <= 1'b1; desc_addr <= '0; st <= S_IDLE;
          end else st <= S_STAT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
  assert_irq_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && desc_addr == '0));
  assert_found_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !irq) |-> (desc_addr != '0));
  assert_skip_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && hit) |=> (done && !irq && !mem_rd && !mem_wr));
  assert_retire_forces_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && desc_retired) |=> (busy && !done));
endmodule

// File: tb/dd_locator_bench.sv
module dd_locator_bench;
  localparam int AW = 32;
  localparam int EPW = 5;
  localparam logic [31:0] BASE = 32'h40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, desc_retired = 1'b0;
  logic [EPW-1:0] req_ep = '0;
  logic busy, done, irq, mem_rd, mem_wr, mem_ready;
  logic [AW-1:0] desc_addr, mem_addr, mem_wdata, mem_rdata;

  dd_locator #(.AW(AW), .EPW(EPW)) u_dd_locator (
    .clk(clk), .rst_n(rst_n), .tbl_base(BASE), .req_valid(req_valid), .req_ep(req_ep),
    .desc_retired(desc_retired), .busy(busy), .done(done), .irq(irq), .desc_addr(desc_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  logic [31:0] mem [0:255];
  logic [31:0] acc_log [0:1023];
  int acc_cnt = 0;
  int wcnt = 0;
  int lat = 0;
  logic poke_en = 1'b0;
  logic [31:0] poke_a = '0, poke_d = '0;

  assign mem_ready = (mem_rd || mem_wr) && (wcnt == lat);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (poke_en) mem[poke_a[9:2]] <= poke_d;
    if (mem_rd || mem_wr) begin
      if (mem_ready) begin
        wcnt <= 0;
        acc_log[acc_cnt[9:0]] <= mem_addr;
        acc_cnt <= acc_cnt + 1;
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
      end else wcnt <= wcnt + 1;
    end
  end

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [EPW-1:0] ep;
    bit             irq;
    logic [31:0]    addr;
    int             nacc;
    int             start;
    string          tag;
  } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) check(1'b0, "unexpected done", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(irq == e.irq, {e.tag, " irq"}, {31'd0, irq}, {31'd0, e.irq});
        check(desc_addr == e.addr, {e.tag, " desc_addr"}, desc_addr, e.addr);
        check(acc_cnt - e.start == e.nacc, {e.tag, " access count"}, acc_cnt - e.start, e.nacc);
        if (e.nacc > 0)
          check(acc_log[e.start[9:0]] == BASE + 4 * e.ep, {e.tag, " R2 first address"},
                acc_log[e.start[9:0]], BASE + 4 * e.ep);
      end
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic run(input int ep, input bit ret, input bit e_irq, input logic [31:0] e_addr,
                     input int nacc, input string tag);
    exp_t e;
    @(negedge clk);
    e.ep = EPW'(ep); e.irq = e_irq; e.addr = e_addr; e.nacc = nacc; e.start = acc_cnt; e.tag = tag;
    q.push_back(e);
    req_valid = 1'b1; req_ep = EPW'(ep); desc_retired = ret;
    @(negedge clk);
    req_valid = 1'b0; desc_retired = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic tests_body;
    for (int i = 0; i < 256; i++) poke(i * 4, 32'd0);
    poke(BASE + 4*2, 32'h100);
    poke(BASE + 4*3, 32'h140);  poke(32'h14C, 32'h1); poke(32'h144, 32'h0);
    poke(BASE + 4*4, 32'h180);  poke(32'h18C, 32'h1); poke(32'h184, 32'h4); poke(32'h180, 32'h0);
    poke(BASE + 4*5, 32'h200);  poke(32'h20C, 32'h1); poke(32'h204, 32'h4); poke(32'h200, 32'h220);
    poke(32'h22C, 32'h1); poke(32'h224, 32'h4); poke(32'h220, 32'h240);
    poke(32'h120, 32'h0);
    @(negedge clk);
    check(!busy && !done && !irq && !mem_rd && !mem_wr, "R1 reset state",
          {27'd0, busy, done, irq, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;

    lat = 0; run(1, 0, 1, 32'h0, 1, "R3 zero slot");
    lat = 2; run(2, 0, 0, 32'h100, 2, "R4 live descriptor");
    run(2, 0, 0, 32'h100, 0, "R7 proceed skip");
    poke(32'h10C, 32'h1); poke(32'h104, 32'h4); poke(32'h100, 32'h120);
    @(negedge clk); desc_retired = 1'b1; @(negedge clk); desc_retired = 1'b0;
    lat = 1; run(2, 0, 0, 32'h120, 6, "R5 R8 follow link after retire");
    check(mem[(BASE + 8) >> 2] == 32'h120, "R6 slot write-back", mem[(BASE + 8) >> 2], 32'h120);
    run(2, 0, 0, 32'h120, 0, "R7 skip on new descriptor");
    lat = 3; run(3, 0, 1, 32'h0, 3, "R9 retired no successor");
    run(3, 0, 1, 32'h0, 3, "R8 irq clears proceed");
    lat = 0; run(4, 0, 1, 32'h0, 5, "R6 zero link");
    check(mem[(BASE + 16) >> 2] == 32'h0, "R6 zero link written", mem[(BASE + 16) >> 2], 32'h0);
    lat = 1; run(5, 0, 0, 32'h240, 10, "R6 two links");
    check(mem[(BASE + 20) >> 2] == 32'h240, "R6 two-link write-back", mem[(BASE + 20) >> 2], 32'h240);
    run(2, 0, 0, 32'h120, 2, "R8 other endpoint cleared proceed");
    lat = 2; run(2, 1, 0, 32'h120, 2, "R8 coincident retire and request");
    run(2, 0, 0, 32'h120, 0, "R7 skip after refetch");
  endtask

  initial begin
    fork
      tests_body();
      begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog", 32'd1, 32'd0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule